// File: doc/BRIEF.md
# Radix-2 Single-Delay-Feedback Butterfly Stage with Constant Rotations

This block is one pipeline stage of a streaming FFT built from radix-2 decimation-in-frequency butterflies that share one feedback delay. Samples arrive one complex value per accepted transfer and are grouped into blocks of `2*DEPTH`. Each sample of the first half of a block is parked in a `DEPTH`-long delay. While the second half arrives, the stage adds each new sample to its partner from the delay and emits the sum, and it writes their difference back into the same delay. During the first half of the next block those differences leave the delay, pass through a constant rotator and are emitted, while the new block's first half fills the delay behind them.

The rotator uses no general multiplier. A parameter gives the stage its role: no rotation, a quarter-turn (multiply by -j, which is a swap of components and one negation), or eighth-turn factors, where multiplication by a diagonal unit vector costs two real scalings by an approximation of 1/sqrt(2) made of shifts and adds. Stages of decreasing depth are chained to build a transform. A general table-driven twiddle multiplier goes between stages, outside this block.

Both stream edges use valid/ready. An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high. The stage stalls as one unit: `in_ready` is high when the output register is empty or when the consumer takes its content in the same cycle. A held output keeps its value until it is taken. The differences of the last block stay in the delay until another block, for example zeros, is pushed in behind them.

Top module: `sdf_r2c_stage`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The first `DEPTH` transfers after reset produce no output: `out_valid` stays 0 after each of them.
- R3: For transfer index c in the range DEPTH..2*DEPTH-1 of a block, the output register in the next cycle holds the sum of that input and input c-DEPTH of the same block, with `out_valid` 1.
- R4: For transfer index c below DEPTH in any block after the first, the output in the next cycle is the rotated difference (input c minus input c+DEPTH) of the previous block. Differences leave in their original order.
- R5: With ROLE=0 the difference is emitted with no rotation.
- R6: With ROLE=1 the differences with c >= DEPTH/2 are multiplied by -j (real out = imaginary diff, imaginary out = minus real diff). The others pass unchanged.
- R7: With ROLE=2 the selector s = floor(4*c/DEPTH) picks the rotation of the difference a+jb: s=0 none; s=1 gives real K(a+b), imaginary K(b-a); s=2 is -j as in R6; s=3 gives real K(b-a), imaginary -K(a+b).
- R8: K(v) is floor(v*181/256), meaning 1/2+1/8+1/16+1/64+1/256 with the result truncated toward minus infinity.
- R9: A cycle with `in_ready` high and `in_valid` low advances nothing, and `out_valid` is 0 in the next cycle.
- R10: `in_ready` equals `out_ready OR NOT out_valid`. While `out_valid` is 1 and `out_ready` is 0, the output value stays unchanged.
- R11: Full-scale inputs (-256 and 255 on 9 bits) never wrap. Outputs are `IN_W+2` bits wide and two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage can take a sample this cycle |
| in_re | input | IN_W | Real part of input, two's complement |
| in_im | input | IN_W | Imaginary part of input, two's complement |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_re | output | IN_W+2 | Real part of output |
| out_im | output | IN_W+2 | Imaginary part of output |

## Verification
If the block counter drifts by even one transfer, the sums of the second half pair the wrong samples, and the next emitted sum is off. The rotation selector also shifts, so the wrong constant shows up within one block. If the delay loses or duplicates a slot, the sums go wrong `DEPTH` transfers later, and the drained differences go wrong another block after that. A rotator error, such as a swapped sign or a wrong rounding in the scaler, shows only on drained samples whose selector is odd or two. For that reason full-scale values sit exactly on those slots. Stall and idle faults show up at once as a changed held value or a spurious `out_valid`.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  // Constant rotation applied to a drained difference
  typedef enum logic [1:0] {
    ROT_ID = 2'd0,  // multiply by 1
    ROT_E1 = 2'd1,  // diagonal, first eighth turn
    ROT_MJ = 2'd2,  // multiply by -j
    ROT_E3 = 2'd3   // diagonal, third eighth turn
  } rot_sel_e;

  // Stage roles
  localparam int ROLE_PLAIN   = 0;
  localparam int ROLE_QUARTER = 1;
  localparam int ROLE_EIGHTH  = 2;

  // 1/sqrt(2) approximated by shifts: 2^-1 + 2^-3 + 2^-4 + 2^-6 + 2^-8
  localparam int KSHIFT = 8;

endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ROLE  = ROLE_EIGHTH
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  output logic     fill_phase,
  output logic     primed,
  output rot_sel_e sel
);

  localparam int CW = $clog2(2 * DEPTH);
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else if (adv) begin
      cnt <= cnt + CW'(1);
      if (cnt == LAST) primed <= 1'b1;
    end
  end

  // Upper half of the block: butterfly active
  assign fill_phase = cnt[CW-1];

  // Rotation selector from the counter's upper bits inside the half-block
  generate
    if (ROLE == ROLE_EIGHTH) begin : g_eighth
      assign sel = rot_sel_e'(cnt[CW-2:CW-3]);
    end else if (ROLE == ROLE_QUARTER) begin : g_quarter
      assign sel = cnt[CW-2] ? ROT_MJ : ROT_ID;
    end else begin : g_plain
      assign sel = ROT_ID;
    end
  endgenerate

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt)) else $error("counter moved without transfer"); // R9

  AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed) else $error("primed flag dropped"); // R4

  AST_PRIME_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == LAST) |=> primed) else $error("not primed after first block"); // R2

endmodule

// File: rtl/sdf_delay.sv
module sdf_delay #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] tap [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
    end else if (adv) begin
      tap[0] <= din;
      for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
    end
  end

  assign dout = tap[DEPTH-1];

endmodule

// File: rtl/sdf_bfly.sv
module sdf_bfly #(
  parameter int W = 10
) (
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic signed [W-1:0] sum_re,
  output logic signed [W-1:0] sum_im,
  output logic signed [W-1:0] dif_re,
  output logic signed [W-1:0] dif_im
);

  // Operands hold IN_W-bit values, so W = IN_W+1 cannot overflow
  assign sum_re = a_re + b_re;
  assign sum_im = a_im + b_im;
  assign dif_re = a_re - b_re;
  assign dif_im = a_im - b_im;

endmodule

// File: rtl/sdf_rotator.sv
module sdf_rotator
  import sdf_pkg::*;
#(
  parameter int IW = 10,
  parameter int OW = 11
) (
  input  logic signed [IW-1:0] d_re,
  input  logic signed [IW-1:0] d_im,
  input  rot_sel_e             sel,
  output logic signed [OW-1:0] r_re,
  output logic signed [OW-1:0] r_im
);

  localparam int PW = OW + KSHIFT;

  logic signed [OW-1:0] xr, xi, psum, pdif, kps, kpd;

  function automatic logic signed [OW-1:0] k_scale(input logic signed [OW-1:0] v);
    logic signed [PW-1:0] e, acc, sh;
    e   = {{KSHIFT{v[OW-1]}}, v};
    acc = (e <<< 7) + (e <<< 5) + (e <<< 4) + (e <<< 2) + e;
    sh  = acc >>> KSHIFT;
    return sh[OW-1:0];
  endfunction

  assign xr   = {{(OW-IW){d_re[IW-1]}}, d_re};
  assign xi   = {{(OW-IW){d_im[IW-1]}}, d_im};
  assign psum = xr + xi;
  assign pdif = xi - xr;
  assign kps  = k_scale(psum);
  assign kpd  = k_scale(pdif);

  always_comb begin
    unique case (sel)
      ROT_E1: begin r_re = kps;  r_im = kpd;  end
      ROT_MJ: begin r_re = xi;   r_im = -xr;  end
      ROT_E3: begin r_re = kpd;  r_im = -kps; end
      default: begin r_re = xr;  r_im = xi;   end
    endcase
  end

endmodule

// File: rtl/sdf_r2c_stage.sv
module sdf_r2c_stage
  import sdf_pkg::*;
#(
  parameter int IN_W  = 9,
  parameter int DEPTH = 8,
  parameter int ROLE  = ROLE_EIGHTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_re,
  input  logic [IN_W-1:0] in_im,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IN_W+1:0] out_re,
  output logic [IN_W+1:0] out_im
);

  localparam int DW = IN_W + 1;  // butterfly growth
  localparam int OW = IN_W + 2;  // headroom for diagonal rotation

  logic adv, fill_phase, primed;
  rot_sel_e sel;

  logic signed [DW-1:0] x_re, x_im, h_re, h_im;
  logic signed [DW-1:0] s_re, s_im, d_re, d_im;
  logic signed [OW-1:0] r_re, r_im, nxt_re, nxt_im;
  logic [2*DW-1:0] dl_in, dl_out;

  assign in_ready = out_ready | ~out_valid;
  assign adv      = in_valid & in_ready;

  assign x_re = {in_re[IN_W-1], in_re};
  assign x_im = {in_im[IN_W-1], in_im};

  sdf_ctrl #(.DEPTH(DEPTH), .ROLE(ROLE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .fill_phase(fill_phase), .primed(primed), .sel(sel)
  );

  // Feedback delay: first-half inputs go in, later replaced by differences
  assign dl_in = fill_phase ? {d_re, d_im} : {x_re, x_im};

  sdf_delay #(.W(2*DW), .DEPTH(DEPTH)) u_delay (
    .clk(clk), .rst_n(rst_n), .adv(adv), .din(dl_in), .dout(dl_out)
  );

  assign h_re = dl_out[2*DW-1:DW];
  assign h_im = dl_out[DW-1:0];

  sdf_bfly #(.W(DW)) u_bfly (
    .a_re(h_re), .a_im(h_im), .b_re(x_re), .b_im(x_im),
    .sum_re(s_re), .sum_im(s_im), .dif_re(d_re), .dif_im(d_im)
  );

  sdf_rotator #(.IW(DW), .OW(OW)) u_rot (
    .d_re(h_re), .d_im(h_im), .sel(sel), .r_re(r_re), .r_im(r_im)
  );

  assign nxt_re = fill_phase ? {s_re[DW-1], s_re} : r_re;
  assign nxt_im = fill_phase ? {s_im[DW-1], s_im} : r_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else if (adv) begin
      out_valid <= fill_phase | primed;
      out_re    <= nxt_re;
      out_im    <= nxt_im;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready) else $error("empty stage refused input"); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)))
    else $error("held output changed"); // R10

  AST_FIRST_HALF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !fill_phase && !primed) |=> !out_valid)
    else $error("output before first block filled"); // R2

  AST_SUM_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fill_phase) |=> out_valid) else $error("sum not emitted"); // R3

  AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid) else $error("output without transfer"); // R9

endmodule

// File: tb/sdf_r2c_stage_test.sv
module sdf_r2c_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 9;
  localparam int OW   = IN_W + 2;
  localparam int NI   = 3;
  localparam int DEP [NI] = '{8, 2, 2};
  localparam int ROL [NI] = '{2, 1, 0};

  // Stimulus table: full-scale pairs sit on slots c and c+8 for c = 0,2,4,6
  localparam int TRE [16] = '{ 255,   3,  255, -100, -256, 17, -256,  90,
                              -256,  -5, -256,   60,  255,  0,  255, -33};
  localparam int TIM [16] = '{ 255,  -7,  255,   40,  255,  0, -256, -91,
                              -256,  12, -256,   61, -256, -128, 255, 127};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [IN_W-1:0] in_re = '0;
  logic [IN_W-1:0] in_im = '0;
  logic rdy [NI];
  logic ov [NI];
  logic [OW-1:0] ore [NI];
  logic [OW-1:0] oim [NI];
  logic [OW-1:0] held_re [NI];
  logic [OW-1:0] held_im [NI];

  int checks = 0;
  int errors = 0;
  int n_acc = 0;
  int sr [64];
  int si [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdf_r2c_stage #(.IN_W(IN_W), .DEPTH(8), .ROLE(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]),
    .in_re(in_re), .in_im(in_im), .out_valid(ov[0]), .out_ready(out_ready),
    .out_re(ore[0]), .out_im(oim[0]));

  sdf_r2c_stage #(.IN_W(IN_W), .DEPTH(2), .ROLE(1)) uut_quarter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]),
    .in_re(in_re), .in_im(in_im), .out_valid(ov[1]), .out_ready(out_ready),
    .out_re(ore[1]), .out_im(oim[1]));

  sdf_r2c_stage #(.IN_W(IN_W), .DEPTH(2), .ROLE(0)) uut_plain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[2]),
    .in_re(in_re), .in_im(in_im), .out_valid(ov[2]), .out_ready(out_ready),
    .out_re(ore[2]), .out_im(oim[2]));

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int kscale(int v);  // R8
    return (v * 181) >>> 8;
  endfunction

  task automatic stim(int n, output int r, output int i);
    int k;
    k = n % 16;
    case ((n / 16) % 3)
      0:       begin r = TRE[k];            i = TIM[k];            end
      1:       begin r = TIM[(k + 5) % 16]; i = TRE[(k + 9) % 16]; end
      default: begin r = TRE[(k * 3) % 16]; i = TIM[(k * 7) % 16]; end
    endcase
  endtask

  // Expected output after accepted transfer n, from the requirements
  task automatic model(int d, int role, int n, output bit v, output int re,
                       output int im, output string tag);
    int b, c, p, ar, ai, s;
    b = n / (2 * d);
    c = n % (2 * d);
    re = 0; im = 0;
    if (c >= d) begin
      v = 1'b1; tag = "R3";
      re = sr[n-d] + sr[n];
      im = si[n-d] + si[n];
    end else if (b == 0) begin
      v = 1'b0; tag = "R2";
    end else begin
      v = 1'b1;
      p = n - 2 * d;
      ar = sr[p] - sr[p+d];
      ai = si[p] - si[p+d];
      if (role == 2) begin s = (c * 4) / d; tag = "R4 R7 R8"; end
      else if (role == 1) begin s = (c >= d / 2) ? 2 : 0; tag = "R4 R6"; end
      else begin s = 0; tag = "R4 R5"; end
      case (s)
        1: begin re = kscale(ar + ai); im = kscale(ai - ar); end
        2: begin re = ai; im = -ar; end
        3: begin re = kscale(ai - ar); im = -kscale(ar + ai); end
        default: begin re = ar; im = ai; end
      endcase
      if (ar == 511 || ar == -511) tag = {tag, " R11"};
    end
  endtask

  task automatic step(bit bubble);
    int r, i, er, ei;
    bit ev;
    string tag;
    in_valid = !bubble;
    if (!bubble) begin
      stim(n_acc, r, i);
      sr[n_acc] = r;
      si[n_acc] = i;
      in_re = r[IN_W-1:0];
      in_im = i[IN_W-1:0];
    end
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      if (bubble) begin
        chk("R9", $sformatf("idle valid inst%0d", k), int'(ov[k]), 0);
      end else begin
        model(DEP[k], ROL[k], n_acc, ev, er, ei, tag);
        chk(tag, $sformatf("valid inst%0d n%0d", k, n_acc), int'(ov[k]), int'(ev));
        if (ev) begin
          chk(tag, $sformatf("re inst%0d n%0d", k, n_acc), int'($signed(ore[k])), er);
          chk(tag, $sformatf("im inst%0d n%0d", k, n_acc), int'($signed(oim[k])), ei);
        end
      end
    end
    if (!bubble) n_acc++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r, i;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      chk("R1", "reset valid", int'(ov[k]), 0);
      chk("R1", "reset ready", int'(rdy[k]), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NI; k++) chk("R1", "post-reset valid", int'(ov[k]), 0);

    // Table-driven stream: three blocks of the deep stage, idle cycles mixed in
    for (int t = 0; t < 56; t++) step(t % 7 == 6);
    step(1'b0);  // opens next block: drained differences are valid

    // Back-pressure: output full, consumer stalled
    for (int k = 0; k < NI; k++) begin
      held_re[k] = ore[k];
      held_im[k] = oim[k];
    end
    out_ready = 1'b0;
    in_valid = 1'b1;
    stim(n_acc, r, i);
    in_re = r[IN_W-1:0];
    in_im = i[IN_W-1:0];
    #1;
    for (int k = 0; k < NI; k++) chk("R10", "ready while stalled", int'(rdy[k]), 0);
    repeat (2) begin
      @(negedge clk);
      for (int k = 0; k < NI; k++) begin
        chk("R10", "held valid", int'(ov[k]), 1);
        chk("R10", "held re", int'(ore[k]), int'(held_re[k]));
        chk("R10", "held im", int'(oim[k]), int'(held_im[k]));
        chk("R10", "ready stays low", int'(rdy[k]), 0);
      end
    end
    out_ready = 1'b1;
    in_valid = 1'b0;
    #1;
    for (int k = 0; k < NI; k++) chk("R10", "ready on take", int'(rdy[k]), 1);
    @(negedge clk);
    for (int k = 0; k < NI; k++) chk("R10", "drained after take", int'(ov[k]), 0);

    // Reset in mid-stream, then restart from an empty delay
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      chk("R1", "mid reset valid", int'(ov[k]), 0);
      chk("R1", "mid reset ready", int'(rdy[k]), 1);
    end
    rst_n = 1'b1;
    n_acc = 0;
    repeat (12) step(1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule